// File: doc/BRIEF.md
# Timer Capture/Compare Unit

This block is the timing core of a general-purpose timer. A counter runs freely, advancing once per tick of a prescaler that divides the system clock by a power of two from 4 to 256. Alternatively, it counts the rising edges of a slow external clock. Around the counter sit a group of capture channels and a group of compare channels, plus one channel whose role software chooses.

A capture channel watches an input pin and copies the counter into its register when the selected edge arrives. A compare channel watches for the counter stepping onto the value in its register. On that step it sets, clears or toggles its output pin, or leaves the pin alone. Every channel event, and the counter wrapping to zero, raises a sticky flag. Each flag has its own enable into a single interrupt line. Software can also fire any compare channel's pin action at once through a force register, and a force leaves that channel's flag untouched.

The block is programmed over a simple single-cycle register bus. Writes are registered on the clock edge. Reads are combinational from the address.

Top module: `cc_timer`

## Requirements
- R1: The counter (address 0, CNT_W bits) steps by one on each prescaler tick. Clock-select codes 0 to 6 in bits [2:0] of the control register (address 2) give one tick every 4, 8, 16, 32, 64, 128 and 256 clocks. Code 7 gives one tick per rising edge of `ext_clk`, which is first passed through a two-flop synchronizer.
- R2: The 9-bit prescaler reads back at address 1 in bits [8:0]. It advances by one every clock, and bits [15:9] read as zero.
- R3: Each capture channel k has a 2-bit edge code at bits [2k+1:2k] of address 3. The codes are 00 off, 01 rising only, 10 falling only and 11 either edge. Its pin goes through two synchronizer flops. On a selected edge, the capture register (address 8+k) loads on the third clock edge after the pin changes, taking the counter value held just before that edge.
- R4: Each compare channel j has a 2-bit action code at bits [2j+1:2j] of address 4 and a compare register at address 12+j. On the clock edge where the counter steps onto the compare value, the pin `cmp_out[j]` is updated and the channel flag is set. The actions are 01 toggle, 10 drive 0 and 11 drive 1.
- R5: The flag register (address 5) is sticky. Its layout is bits 0 to 2 for captures 1 to 3, bit 3 for the shared channel, bits 4 to 7 for compares 1 to 4, and bit 8 for overflow. Writing 1 to a bit clears it, writing 0 leaves it, and a new event in the same cycle wins over the clear.
- R6: With action code 00, a compare match leaves the pin unchanged but still sets the channel flag.
- R7: Writing 1 to a compare channel's flag-position bit in the force register (address 7) applies that channel's action on the write's clock edge and does not set its flag.
- R8: `irq` is high exactly while some flag bit and the same bit of the enable register (address 6) are both 1.
- R9: The overflow flag (bit 8) sets on the edge where the counter wraps from all ones to zero.
- R10: Control bit 3 picks the shared channel's role. At 0 it is capture channel 4, using `cap_in[3]`, edge bits [7:6], address 11 and flag bit 3, and its compare action and force have no effect on `cmp_out[4]`. At 1 it is compare channel 5, using `cmp_out[4]`, action bits [9:8], address 16, flag bit 3 and force bit 3, and edges on `cap_in[3]` leave address 11 unchanged.
- R11: Reset clears the counter, all flags, all registers and all compare pins, and holds `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (5) | Register address |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for `bus_addr` |
| ext_clk | input | 1 | Slow external count clock |
| cap_in | input | NCAP+1 (4) | Capture pins, top bit for the shared channel |
| cmp_out | output | NCMP+1 (5) | Compare pins, top bit for the shared channel |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `ext_clk` and the capture pins change slowly compared with the system clock. They also assume that a write to the flag register never lands in the same cycle as the event it would clear. The bench holds every pin level for several clocks, keeps external clock phases at three clocks, and orders clears before the stimulus it then examines. Compare targets sit a few ticks ahead of the counter, and unrelated channels are parked far from it, so that no second match falls inside a check window.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  localparam int PSC_W = 9;

  // register addresses
  localparam int A_CNT   = 0;
  localparam int A_PSC   = 1;
  localparam int A_CTRL  = 2;
  localparam int A_EDGE  = 3;
  localparam int A_ACT   = 4;
  localparam int A_FLAG  = 5;
  localparam int A_IEN   = 6;
  localparam int A_FORCE = 7;
  localparam int A_CAP0  = 8;

  localparam logic [2:0] PSC_EXT = 3'd7;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pin_act_e;

  // tick when the low (sel+2) prescaler bits are all ones
  function automatic logic div_tick(input logic [2:0] sel, input logic [PSC_W-1:0] psc);
    logic t;
    t = 1'b1;
    for (int b = 0; b < PSC_W; b++) begin
      if (b < int'(sel) + 2) t = t & psc[b];
    end
    return t;
  endfunction

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    case (sel)
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      EDGE_ANY:  return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic pin_after(input logic [1:0] act, input logic cur);
    case (act)
      ACT_TOGGLE: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction

  // flag/force bit position of compare channel ci (ci == ncmp is the shared one)
  function automatic int cmp_slot(input int ci, input int ncap, input int ncmp);
    return (ci == ncmp) ? ncap : ncap + 1 + ci;
  endfunction

endpackage

// File: rtl/cc_prescaler.sv
module cc_prescaler
  import cc_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel,
  input  logic             ext_clk,
  output logic [PSC_W-1:0] psc_val,
  output logic             tick
);

  logic [PSC_W-1:0] psc_q;
  logic             ext_s1, ext_s2, ext_s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      ext_s1 <= 1'b0;
      ext_s2 <= 1'b0;
      ext_s3 <= 1'b0;
    end else begin
      psc_q  <= psc_q + 1'b1;
      ext_s1 <= ext_clk;
      ext_s2 <= ext_s1;
      ext_s3 <= ext_s2;
    end
  end

  assign psc_val = psc_q;
  assign tick    = (sel == PSC_EXT) ? (ext_s2 & ~ext_s3) : div_tick(sel, psc_q);

endmodule

// File: rtl/cc_capture_ch.sv
module cc_capture_ch
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       edge_sel,
  input  logic             pin,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_q,
  output logic             evt
);

  logic s1, s2, s_prev;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s1     <= pin;
      s2     <= s1;
      s_prev <= s2;
    end
  end

  assign rise = s2 & ~s_prev;
  assign fall = ~s2 & s_prev;
  assign evt  = en & edge_hit(edge_sel, rise, fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cap_q <= '0;
    else if (evt) cap_q <= cnt;
  end

endmodule

// File: rtl/cc_compare_ch.sv
module cc_compare_ch
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       act,
  input  logic [CNT_W-1:0] ref_val,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             tick,
  input  logic             force_req,
  output logic             pin_q,
  output logic             hit,
  output logic             frc_hit
);

  assign hit     = en & tick & (cnt_nxt == ref_val);
  assign frc_hit = en & force_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pin_q <= 1'b0;
    else if (hit || frc_hit)  pin_q <= pin_after(act, pin_q);
  end

endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCAP   = 3,
  parameter int NCMP   = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk,
  input  logic [NCAP:0]     cap_in,
  output logic [NCMP:0]     cmp_out,
  output logic              irq
);

  localparam int NCAPCH   = NCAP + 1;
  localparam int NCMPCH   = NCMP + 1;
  localparam int NFLAG    = NCAP + NCMP + 2;
  localparam int OVF_BIT  = NFLAG - 1;
  localparam int CMP_BASE = A_CAP0 + NCAPCH;

  logic [2:0]          psc_sel_q;
  logic                share_cmp_q;
  logic [2*NCAPCH-1:0] edge_q;
  logic [2*NCMPCH-1:0] act_q;
  logic [NFLAG-1:0]    ien_q;
  logic [NFLAG-1:0]    flags_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    cmp_ref [NCMPCH];
  logic [CNT_W-1:0]    cap_arr [NCAPCH];

  // named internal events
  logic [PSC_W-1:0]    psc_val;
  logic                cnt_tick;
  logic [CNT_W-1:0]    cnt_nxt;
  logic                ovf_evt;
  logic [NCAPCH-1:0]   cap_evt;
  logic [NCMPCH-1:0]   cmp_hit;
  logic [NCMPCH-1:0]   frc_pulse;
  logic [NFLAG-1:0]    frc_wr;
  logic [NFLAG-1:0]    flag_set;
  logic [NFLAG-1:0]    flag_clr;

  function automatic logic wr_at(input int a);
    return bus_wr && (bus_addr == ADDR_W'(a));
  endfunction

  cc_prescaler u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (psc_sel_q),
    .ext_clk (ext_clk),
    .psc_val (psc_val),
    .tick    (cnt_tick)
  );

  assign cnt_nxt = cnt_q + 1'b1;
  assign ovf_evt = cnt_tick && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_tick) cnt_q <= cnt_nxt;
  end

  // capture channels, the last one shared
  for (genvar k = 0; k < NCAPCH; k++) begin : g_cap
    logic en;
    assign en = (k == NCAP) ? ~share_cmp_q : 1'b1;
    cc_capture_ch #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .edge_sel (edge_q[2*k +: 2]),
      .pin      (cap_in[k]),
      .cnt      (cnt_q),
      .cap_q    (cap_arr[k]),
      .evt      (cap_evt[k])
    );
  end

  assign frc_wr = wr_at(A_FORCE) ? bus_wdata[NFLAG-1:0] : '0;

  // compare channels, the last one shared
  for (genvar c = 0; c < NCMPCH; c++) begin : g_cmp
    localparam int SLOT = cmp_slot(c, NCAP, NCMP);
    logic en;
    assign en = (c == NCMP) ? share_cmp_q : 1'b1;
    cc_compare_ch #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .act       (act_q[2*c +: 2]),
      .ref_val   (cmp_ref[c]),
      .cnt_nxt   (cnt_nxt),
      .tick      (cnt_tick),
      .force_req (frc_wr[SLOT]),
      .pin_q     (cmp_out[c]),
      .hit       (cmp_hit[c]),
      .frc_hit   (frc_pulse[c])
    );
  end

  always_comb begin
    flag_set = '0;
    for (int k = 0; k < NCAPCH; k++) begin
      if (cap_evt[k]) flag_set[k] = 1'b1;
    end
    for (int c = 0; c < NCMPCH; c++) begin
      if (cmp_hit[c]) flag_set[cmp_slot(c, NCAP, NCMP)] = 1'b1;
    end
    flag_set[OVF_BIT] = ovf_evt;
  end

  assign flag_clr = wr_at(A_FLAG) ? bus_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_sel_q   <= '0;
      share_cmp_q <= 1'b0;
      edge_q      <= '0;
      act_q       <= '0;
      ien_q       <= '0;
      for (int c = 0; c < NCMPCH; c++) cmp_ref[c] <= '0;
    end else begin
      if (wr_at(A_CTRL)) begin
        psc_sel_q   <= bus_wdata[2:0];
        share_cmp_q <= bus_wdata[3];
      end
      if (wr_at(A_EDGE)) edge_q <= bus_wdata[2*NCAPCH-1:0];
      if (wr_at(A_ACT))  act_q  <= bus_wdata[2*NCMPCH-1:0];
      if (wr_at(A_IEN))  ien_q  <= bus_wdata[NFLAG-1:0];
      for (int c = 0; c < NCMPCH; c++) begin
        if (wr_at(CMP_BASE + c)) cmp_ref[c] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  assign irq = |(flags_q & ien_q);

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CNT):  bus_rdata = DATA_W'(cnt_q);
      ADDR_W'(A_PSC):  bus_rdata = DATA_W'(psc_val);
      ADDR_W'(A_CTRL): bus_rdata = DATA_W'({share_cmp_q, psc_sel_q});
      ADDR_W'(A_EDGE): bus_rdata = DATA_W'(edge_q);
      ADDR_W'(A_ACT):  bus_rdata = DATA_W'(act_q);
      ADDR_W'(A_FLAG): bus_rdata = DATA_W'(flags_q);
      ADDR_W'(A_IEN):  bus_rdata = DATA_W'(ien_q);
      default: begin
        for (int k = 0; k < NCAPCH; k++) begin
          if (bus_addr == ADDR_W'(A_CAP0 + k)) bus_rdata = DATA_W'(cap_arr[k]);
        end
        for (int c = 0; c < NCMPCH; c++) begin
          if (bus_addr == ADDR_W'(CMP_BASE + c)) bus_rdata = DATA_W'(cmp_ref[c]);
        end
      end
    endcase
  end

endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCAP  = 3,
  parameter int NCMP  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CNT_W-1:0]       cnt_q,
  input logic                   cnt_tick,
  input logic [PSC_W-1:0]       psc_val,
  input logic [NCAP+NCMP+1:0]   flags_q,
  input logic [NCMP:0]          cmp_hit,
  input logic [NCMP:0]          frc_pulse,
  input logic [NCMP:0]          cmp_out
);

  localparam int OVF_BIT = NCAP + NCMP + 1;

  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(cnt_q));

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  assert_psc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> psc_val == PSC_W'($past(psc_val) + 1'b1));

  assert_ovf_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[OVF_BIT]) |-> (cnt_q == '0 && $past(cnt_q) == '1));

  for (genvar c = 0; c <= NCMP; c++) begin : g_c
    localparam int SLOT = cmp_slot(c, NCAP, NCMP);

    assert_force_noflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frc_pulse[c] && !cmp_hit[c] && !flags_q[SLOT] && (c != NCMP)) |=> !flags_q[SLOT]);

    assert_pin_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmp_hit[c] || frc_pulse[c]) |=> $stable(cmp_out[c]));
  end

endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W), .NCAP(NCAP), .NCMP(NCMP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_q     (cnt_q),
  .cnt_tick  (cnt_tick),
  .psc_val   (psc_val),
  .flags_q   (flags_q),
  .cmp_hit   (cmp_hit),
  .frc_pulse (frc_pulse),
  .cmp_out   (cmp_out)
);

// File: tb/cc_timer_tb.sv
module cc_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 10;
  localparam int CMASK      = (1 << CW) - 1;

  localparam int AD_CNT = 0, AD_PSC = 1, AD_CTRL = 2, AD_EDGE = 3, AD_ACT = 4;
  localparam int AD_FLAG = 5, AD_IEN = 6, AD_FORCE = 7, AD_CAP = 8, AD_CMP = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_clk = 1'b0;
  logic [3:0]  cap_in = '0;
  logic [4:0]  cmp_out;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] edge_sh = '0;
  logic [15:0] act_sh = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cc_timer #(.CNT_W(CW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_clk   (ext_clk),
    .cap_in    (cap_in),
    .cmp_out   (cmp_out),
    .irq       (irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 5'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic wr(input int a, input int d);
    bus_wr    = 1'b1;
    bus_addr  = 5'(a);
    bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cap_edge(input int ch, input logic lvl, input bit hit, input string req);
    int old, c, now, f;
    wr(AD_FLAG, 'h1ff);
    repeat (5) @(negedge clk);
    rd(AD_CAP + ch, old);
    cap_in[ch] = lvl;
    @(negedge clk);
    @(negedge clk);
    rd(AD_CNT, c);
    @(negedge clk);
    rd(AD_CAP + ch, now);
    chk(req, "capture value", now, hit ? c : old);
    rd(AD_FLAG, f);
    chk(req, "capture flag", (f >> ch) & 1, int'(hit));
  endtask

  task automatic cmp_case(input int ch, input int act, input bit active, input string req);
    int c, tgt, v, f, p_start, p_before, exp_pin, slot;
    bit seen;
    slot = (ch == 4) ? 3 : 4 + ch;
    act_sh[2*ch +: 2] = 2'(act);
    wr(AD_ACT, int'(act_sh));
    rd(AD_CNT, c);
    tgt = (c + 6) & CMASK;
    wr(AD_CMP + ch, tgt);
    wr(AD_FLAG, 'h1ff);
    p_start  = int'(cmp_out[ch]);
    p_before = p_start;
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rd(AD_CNT, v);
      if (v == tgt) begin
        seen = 1'b1;
        break;
      end
      p_before = int'(cmp_out[ch]);
    end
    if (!active)       exp_pin = p_start;
    else if (act == 1) exp_pin = 1 - p_start;
    else if (act == 2) exp_pin = 0;
    else if (act == 3) exp_pin = 1;
    else               exp_pin = p_start;
    chk(req, "target reached", int'(seen), 1);
    chk(req, "pin before match", p_before, p_start);
    chk(req, "pin at match", int'(cmp_out[ch]), exp_pin);
    rd(AD_FLAG, f);
    chk(req, "match flag", (f >> slot) & 1, int'(active));
  endtask

  task automatic t_reset();
    int d;
    @(negedge clk);
    rd(AD_CNT, d);  chk("R11", "counter in reset", d, 0);
    rd(AD_FLAG, d); chk("R11", "flags in reset", d, 0);
    rd(AD_CAP, d);  chk("R11", "capture reg in reset", d, 0);
    chk("R11", "pins in reset", int'(cmp_out), 0);
    chk("R11", "irq in reset", int'(irq), 0);
  endtask

  task automatic t_prescaler();
    int a, b;
    @(negedge clk); rd(AD_PSC, a);
    @(negedge clk); rd(AD_PSC, b);
    chk("R2", "prescaler step", b, (a + 1) & 'h1ff);
    chk("R2", "prescaler upper bits", (a >> 9) | (b >> 9), 0);
  endtask

  task automatic t_rate(input int sel, input int m);
    int c0, c1;
    wr(AD_CTRL, sel);
    rd(AD_CNT, c0);
    repeat (m * (4 << sel)) @(negedge clk);
    rd(AD_CNT, c1);
    chk("R1", $sformatf("ticks with select %0d", sel), (c1 - c0) & CMASK, m);
  endtask

  task automatic t_ext();
    int c0, c1;
    wr(AD_CTRL, 7);
    repeat (4) @(negedge clk);
    rd(AD_CNT, c0);
    for (int i = 0; i < 5; i++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(AD_CNT, c1);
    chk("R1", "external edges counted", (c1 - c0) & CMASK, 5);
    wr(AD_CTRL, 0);
  endtask

  task automatic t_capture();
    edge_sh[7:0] = 8'h39;   // ch0 rise, ch1 fall, ch2 any, ch3 off
    wr(AD_EDGE, int'(edge_sh));
    cap_edge(0, 1'b1, 1'b1, "R3");
    cap_edge(0, 1'b0, 1'b0, "R3");
    cap_edge(1, 1'b1, 1'b0, "R3");
    cap_edge(1, 1'b0, 1'b1, "R3");
    cap_edge(2, 1'b1, 1'b1, "R3");
    cap_edge(2, 1'b0, 1'b1, "R3");
    cap_edge(3, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_flags();
    int f;
    cap_edge(0, 1'b1, 1'b1, "R5");
    wr(AD_FLAG, 0);
    rd(AD_FLAG, f); chk("R5", "zero write keeps flag", f & 1, 1);
    wr(AD_FLAG, 1);
    rd(AD_FLAG, f); chk("R5", "one write clears flag", f & 1, 0);
    cap_in[0] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_compare();
    cmp_case(0, 1, 1'b1, "R4");
    cmp_case(0, 2, 1'b1, "R4");
    cmp_case(0, 3, 1'b1, "R4");
    cmp_case(0, 0, 1'b1, "R6");
    cmp_case(0, 1, 1'b1, "R4");
    cmp_case(2, 3, 1'b1, "R4");
  endtask

  task automatic t_force();
    int c, f;
    act_sh[3:2] = 2'b11;
    wr(AD_ACT, int'(act_sh));
    rd(AD_CNT, c);
    wr(AD_CMP + 1, (c + 512) & CMASK);
    wr(AD_FLAG, 'h1ff);
    wr(AD_FORCE, 1 << 5);
    chk("R7", "forced drive high", int'(cmp_out[1]), 1);
    rd(AD_FLAG, f); chk("R7", "force leaves flag", (f >> 5) & 1, 0);
    act_sh[3:2] = 2'b01;
    wr(AD_ACT, int'(act_sh));
    wr(AD_FORCE, 1 << 5);
    chk("R7", "forced toggle", int'(cmp_out[1]), 0);
    act_sh[3:2] = 2'b00;
    wr(AD_ACT, int'(act_sh));
    wr(AD_FORCE, 1 << 5);
    chk("R7", "forced with no action", int'(cmp_out[1]), 0);
  endtask

  task automatic t_irq();
    wr(AD_IEN, 1);
    wr(AD_FLAG, 'h1ff);
    chk("R8", "irq idle", int'(irq), 0);
    cap_edge(0, 1'b1, 1'b1, "R8");
    chk("R8", "irq on enabled flag", int'(irq), 1);
    wr(AD_IEN, 0);
    chk("R8", "irq masked", int'(irq), 0);
    wr(AD_IEN, 1);
    chk("R8", "irq unmasked", int'(irq), 1);
    wr(AD_FLAG, 1);
    chk("R8", "irq after clear", int'(irq), 0);
    wr(AD_IEN, 0);
    cap_in[0] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_overflow();
    int prev, v, f, f_prev;
    bit seen;
    wr(AD_FLAG, 'h1ff);
    rd(AD_CNT, prev);
    rd(AD_FLAG, f_prev);
    seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      rd(AD_CNT, v);
      rd(AD_FLAG, f);
      if (v == 0 && prev == CMASK) begin
        seen = 1'b1;
        break;
      end
      prev = v;
      f_prev = f;
    end
    chk("R9", "wrap observed", int'(seen), 1);
    chk("R9", "overflow flag before wrap", (f_prev >> 8) & 1, 0);
    chk("R9", "overflow flag at wrap", (f >> 8) & 1, 1);
  endtask

  task automatic t_shared();
    int d;
    wr(AD_CTRL, 0);
    edge_sh[7:6] = 2'b01;
    wr(AD_EDGE, int'(edge_sh));
    cap_in[3] = 1'b0;
    repeat (5) @(negedge clk);
    cap_edge(3, 1'b1, 1'b1, "R10");
    cmp_case(4, 1, 1'b0, "R10");
    wr(AD_FORCE, 1 << 3);
    chk("R10", "force ignored in capture role", int'(cmp_out[4]), 0);
    wr(AD_CTRL, 8);
    cap_in[3] = 1'b0;
    repeat (5) @(negedge clk);
    cap_edge(3, 1'b1, 1'b0, "R10");
    cmp_case(4, 1, 1'b1, "R10");
    wr(AD_FORCE, 1 << 3);
    chk("R10", "force in compare role", int'(cmp_out[4]), 0);
    rd(AD_CTRL, d);
    chk("R10", "control readback", d, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_prescaler();
    t_rate(0, 10);
    t_rate(3, 5);
    t_rate(6, 3);
    t_ext();
    t_capture();
    t_flags();
    t_compare();
    t_force();
    t_irq();
    t_overflow();
    t_shared();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule